// File: doc/BRIEF.md
# Flash-to-RAM Overlay Address Remapper

This block sits between a single-cycle synchronous CPU bus and two memory ports: a read-only flash port and an on-chip RAM port. It lets one 4 KB page of on-chip RAM stand in for one of the eight 4 KB blocks at the bottom of flash. Calibration data can then be edited live while code keeps using the data's flash address.

A small control register holds an enable bit and a 3-bit block number. While the enable bit is set, reads and writes to the chosen flash block go to the RAM page at 0xFFFF0000–0xFFFF0FFF, using the low 12 address bits, and the flash chip-select stays low. The same RAM page also answers at its own window, so both addresses reach the same storage. Flash blocks at 0x008000 and above are never redirected. A write to flash that is not redirected is dropped and produces a one-cycle error pulse. Read data comes back through one register stage.

Top module: `ovl_remap_top`

## Requirements
- R1: After reset the control register is zero (overlay off, block 0 selected), and `bus_rdata` and `bus_err` are 0.
- R2: A cycle with `reg_we` high loads `reg_wdata`: bit 3 is the enable and bits 2:0 are the block number. The bus access in that same cycle still uses the old setting. The new setting applies from the following cycle.
- R3: With the overlay enabled, a read where `bus_addr[31:15]` is 0 and `bus_addr[14:12]` equals the block number asserts `ram_cs` with `ram_addr = bus_addr[11:0]`, keeps `flash_cs` low, and returns RAM data.
- R4: With the overlay enabled, a write to the selected block asserts `ram_cs` and `ram_we`. The written word can then be read back at the same offset in the RAM window.
- R5: Reads in the flash range (`bus_addr[31:20]` = 0) outside the redirected block assert `flash_cs` with `flash_addr = bus_addr[19:0]` and return flash data. This includes unselected blocks 0–7 and every address at or above 0x008000.
- R6: With the overlay disabled, every flash-range read goes to flash, whatever the block number is.
- R7: Accesses with `bus_addr[31:12]` = 0xFFFF0 reach the RAM port in both overlay states, for reads and writes, with no error.
- R8: A write to a flash-range address that is not redirected asserts no chip-select. It raises `bus_err` for exactly the one cycle after the request.
- R9: `bus_rdata` updates on the clock edge that ends a read request and holds its value through cycles that carry no read.
- R10: An address outside both the flash range and the RAM window asserts no chip-select. A read of it returns 0, and a write to it raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Control value: bit 3 enable, bits 2:0 block number |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | CPU byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a dropped flash write |
| flash_cs | output | 1 | Flash read select |
| flash_addr | output | 20 | Flash byte address |
| flash_rdata | input | 32 | Flash read data (combinational) |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 12 | RAM page byte offset |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data (combinational) |

## Verification
If the enable bit or the block number held a wrong value, the next access would show it at the ports. A read of the intended block would raise `flash_cs` instead of `ram_cs`, or the reverse, in the same cycle as the request. The returned word would then differ from the expected value one edge later. The bench therefore sweeps every block number in both overlay states, reading each block, a block above 32 KB and the RAM window. Any fault in the decode shows up as a wrong chip-select, a wrong `bus_rdata`, or a missing or extra `bus_err` pulse within one cycle.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int PAGE_BITS  = 12;
    localparam int NUM_BLK    = 8;
    localparam int SEL_W      = $clog2(NUM_BLK);
    localparam int FLASH_BITS = 20;
    localparam int CTRL_W     = SEL_W + 1;
    localparam logic [ADDR_W-1:0] RAM_BASE = 32'hFFFF_0000;
    localparam int OVL_TOP    = PAGE_BITS + SEL_W;

    typedef enum logic [1:0] {
        AC_NONE  = 2'd0,
        AC_FLASH = 2'd1,
        AC_OVL   = 2'd2,
        AC_RAM   = 2'd3
    } acc_class_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ovl_ctrl_t;

    function automatic acc_class_e classify(input logic [ADDR_W-1:0] a,
                                            input ovl_ctrl_t c);
        logic in_flash, in_ram, in_ovl;
        in_flash = (a[ADDR_W-1:FLASH_BITS] == '0);
        in_ram   = (a[ADDR_W-1:PAGE_BITS] == RAM_BASE[ADDR_W-1:PAGE_BITS]);
        in_ovl   = in_flash && c.en
                   && (a[FLASH_BITS-1:OVL_TOP] == '0)
                   && (a[OVL_TOP-1:PAGE_BITS] == c.sel);
        if (in_ram)        return AC_RAM;
        else if (in_ovl)   return AC_OVL;
        else if (in_flash) return AC_FLASH;
        else               return AC_NONE;
    endfunction
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ovl_ctrl_t         ctrl
);
    ovl_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (wr) ctrl_q <= ovl_ctrl_t'(wdata);
    end

    assign ctrl = ctrl_q;

    // R1
    ctrl_reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == '0));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr) && !$past(rst)) |-> $stable(ctrl_q));
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
    import ovl_pkg::*;
(
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  ovl_ctrl_t             ctrl,
    output acc_class_e            acc_class,
    output logic                  flash_cs,
    output logic [FLASH_BITS-1:0] flash_addr,
    output logic                  ram_cs,
    output logic                  ram_we,
    output logic [PAGE_BITS-1:0]  ram_addr
);
    always_comb begin
        acc_class  = classify(bus_addr, ctrl);
        flash_cs   = bus_req && !bus_we && (acc_class == AC_FLASH);
        ram_cs     = bus_req && ((acc_class == AC_RAM) || (acc_class == AC_OVL));
        ram_we     = ram_cs && bus_we;
        flash_addr = bus_addr[FLASH_BITS-1:0];
        ram_addr   = bus_addr[PAGE_BITS-1:0];
    end
endmodule

// File: rtl/ovl_rdata_stage.sv
module ovl_rdata_stage
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  acc_class_e        acc_class,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    logic [DATA_W-1:0] rd_q;
    logic              err_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (acc_class)
            AC_FLASH:       rd_mux = flash_rdata;
            AC_OVL, AC_RAM: rd_mux = ram_rdata;
            default:        rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (bus_req && !bus_we) rd_q <= rd_mux;
            err_q <= bus_req && bus_we && (acc_class == AC_FLASH);
        end
    end

    assign bus_rdata = rd_q;
    assign bus_err   = err_q;

    // R8
    err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(bus_req) && $past(bus_we)));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(bus_req) && !$past(bus_we))) |-> $stable(bus_rdata));
endmodule

// File: rtl/ovl_remap_top.sv
module ovl_remap_top
    import ovl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [CTRL_W-1:0]     reg_wdata,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_err,
    output logic                  flash_cs,
    output logic [FLASH_BITS-1:0] flash_addr,
    input  logic [DATA_W-1:0]     flash_rdata,
    output logic                  ram_cs,
    output logic                  ram_we,
    output logic [PAGE_BITS-1:0]  ram_addr,
    output logic [DATA_W-1:0]     ram_wdata,
    input  logic [DATA_W-1:0]     ram_rdata
);
    ovl_ctrl_t  ctrl;
    acc_class_e acc_class;

    ovl_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_we),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    ovl_decode u_dec (
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .ctrl       (ctrl),
        .acc_class  (acc_class),
        .flash_cs   (flash_cs),
        .flash_addr (flash_addr),
        .ram_cs     (ram_cs),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr)
    );

    ovl_rdata_stage u_rd (
        .clk         (clk),
        .rst         (rst),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .acc_class   (acc_class),
        .flash_rdata (flash_rdata),
        .ram_rdata   (ram_rdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err)
    );

    assign ram_wdata = bus_wdata;

    // R3
    flash_ram_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(flash_cs && ram_cs));

    // R3
    ovl_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_cs && (bus_addr[ADDR_W-1:FLASH_BITS] == '0))
            |-> (ctrl.en && (bus_addr[OVL_TOP-1:PAGE_BITS] == ctrl.sel)));

    // R5
    high_flash_no_ram_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr[ADDR_W-1:FLASH_BITS] == '0) && (bus_addr[FLASH_BITS-1:OVL_TOP] != '0))
            |-> !ram_cs);

    // R8
    flash_never_written_chk: assert property (@(posedge clk) disable iff (rst)
        flash_cs |-> !bus_we);

    // R4
    ram_we_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_cs);
endmodule

// File: tb/tb_ovl_remap_top.sv
module tb_ovl_remap_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [3:0]  reg_wdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_err, flash_cs, ram_cs, ram_we;
    logic [19:0] flash_addr;
    logic [11:0] ram_addr;
    logic [31:0] flash_rdata, ram_rdata, ram_wdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ram_mem [1024];

    always #2 clk = ~clk;

    ovl_remap_top dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .flash_cs(flash_cs), .flash_addr(flash_addr), .flash_rdata(flash_rdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural memories
    assign flash_rdata = {12'hC0D, flash_addr};
    assign ram_rdata   = ram_mem[ram_addr[11:2]];
    always @(posedge clk) if (ram_cs && ram_we) ram_mem[ram_addr[11:2]] <= ram_wdata;

    localparam logic [31:0] ADDR_TAB [10] = '{
        32'h0000_0124, 32'h0000_1124, 32'h0000_2124, 32'h0000_3124,
        32'h0000_4124, 32'h0000_5124, 32'h0000_6124, 32'h0000_7124,
        32'h0000_9124, 32'hFFFF_0124 };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic en, input logic [2:0] sel);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = {en, sel};
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // read: checks selects in the request cycle, data after the edge
    task automatic rd(input string req, input logic [31:0] a,
                      input logic exp_f, input logic exp_r, input logic [31:0] exp_d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk({req, " flash_cs"}, {31'd0, flash_cs}, {31'd0, exp_f});
        chk({req, " ram_cs"},   {31'd0, ram_cs},   {31'd0, exp_r});
        if (exp_r) chk({req, " ram_addr"}, {20'd0, ram_addr}, {20'd0, a[11:0]});
        if (exp_f) chk({req, " flash_addr"}, {12'd0, flash_addr}, {12'd0, a[19:0]});
        @(negedge clk);
        bus_req = 1'b0;
        chk({req, " rdata"}, bus_rdata, exp_d);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) ram_mem[i] = 32'h5A00_0000 | i;
        rst = 1'b1; reg_we = 1'b0; reg_wdata = '0;
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 err", {31'd0, bus_err}, 32'h0);
        rd("R1 block0 to flash", 32'h0000_0040, 1'b1, 1'b0, {12'hC0D, 20'h00040});

        // table sweep: R3 R5 R6 R7
        for (int en = 0; en < 2; en++) begin
            for (int sel = 0; sel < 8; sel++) begin
                set_ctrl(en[0], sel[2:0]);
                for (int k = 0; k < 10; k++) begin
                    logic is_ram;
                    logic [31:0] a, exp_d;
                    a = ADDR_TAB[k];
                    is_ram = (k == 9) || (en == 1 && k == sel);
                    exp_d = is_ram ? (32'h5A00_0000 | {22'd0, a[11:2]})
                                   : {12'hC0D, a[19:0]};
                    rd(is_ram ? (k == 9 ? "R7 ram window" : "R3 overlay")
                              : (en == 1 ? "R5 flash" : "R6 flash off"),
                       a, !is_ram, is_ram, exp_d);
                end
            end
        end

        // R4: write through overlay, read back at RAM window
        set_ctrl(1'b1, 3'd5);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 32'h0000_5A08; bus_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R4 ram_we", {31'd0, ram_we}, 32'd1);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R4 no err", {31'd0, bus_err}, 32'd0);
        rd("R4 readback window", 32'hFFFF_0A08, 1'b0, 1'b1, 32'hDEAD_BEEF);

        // R7: RAM window write, read at overlay address
        wr(32'hFFFF_0100, 32'h1234_5678);
        rd("R7 write then overlay read", 32'h0000_5100, 1'b0, 1'b1, 32'h1234_5678);

        // R8: write to non-selected flash block
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 32'h0000_2000; bus_wdata = 32'h0BAD_0BAD;
        #1;
        chk("R8 no cs", {30'd0, flash_cs, ram_cs}, 32'd0);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R8 err pulse", {31'd0, bus_err}, 32'd1);
        @(negedge clk);
        chk("R8 err one cycle", {31'd0, bus_err}, 32'd0);
        rd("R8 ram untouched", 32'hFFFF_0000, 1'b0, 1'b1, 32'h5A00_0000);

        // R9: rdata holds with idle cycles and writes
        repeat (2) @(negedge clk);
        chk("R9 hold idle", bus_rdata, 32'h5A00_0000);
        wr(32'hFFFF_0004, 32'hAAAA_5555);
        chk("R9 hold on write", bus_rdata, 32'h5A00_0000);

        // R10: unmapped address
        rd("R10 unmapped read", 32'h4000_0000, 1'b0, 1'b0, 32'h0);
        wr(32'h4000_0000, 32'h1);
        chk("R10 no err", {31'd0, bus_err}, 32'd0);

        // R2: register write cycle uses old setting, next cycle the new one
        set_ctrl(1'b0, 3'd0);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = {1'b1, 3'd3};
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 32'h0000_3010;
        #1;
        chk("R2 same cycle old", {30'd0, flash_cs, ram_cs}, 32'd2);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R2 next cycle new", {30'd0, flash_cs, ram_cs}, 32'd1);
        @(negedge clk);
        bus_req = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule